// File: doc/BRIEF.md
# Masked Page Request Matcher

This block holds a programmed page request and compares it against each received page header. The request is made of seven digit columns: magazine, page tens, page units, hours tens, hours units, minutes tens and minutes units. Each column carries its own "do care" flag, so one request can select a plain page number or a specific timed subpage. A controller loads the request through a start-column pointer. The pointer steps forward by one column on each byte written.

On every header strobe the block compares the cared digits against the request. A header counts as a match only when every cared digit is equal and none of the cared bytes carries a Hamming error flag. A match lowers an active-low found flag and clears the "page being looked for" flag. When the request's hold bit is high, a match also raises a capture enable. That enable stays high until a later header from the same magazine arrives that does not qualify.

Top module: `pgm_matcher`

## Requirements
- R1: After synchronous reset, `found_n` is 1, `looking` is 0, `capture_en` is 0, and all seven table entries are zero. With every do-care flag clear, any header with no Hamming error matches.
- R2: Each table entry is 5 bits wide. Bit 4 is the do-care flag. Column 0 holds the magazine in bits 2:0 and the hold bit in bit 3. Columns 1 to 6 hold page tens, page units, hours tens, hours units, minutes tens and minutes units in their low bits.
- R3: `cfg_start_we` loads the write pointer from `cfg_start_col`. Each data write stores into the pointed column and advances the pointer, wrapping from column 6 to column 0. A data write while the pointer is 7 is discarded and moves the pointer to 0.
- R4: When `cfg_start_we` and `cfg_data_we` are high in the same cycle, the pointer loads and the data byte is dropped.
- R5: A digit takes part in the comparison only when its do-care bit is 1. It is compared over its own width only: magazine 3 bits, page tens and units 4 bits, hours tens 2 bits, hours units 4 bits, minutes tens 3 bits, minutes units 4 bits. Higher entry bits are ignored.
- R6: A header whose cared byte has its `hdr_ham_err` bit set (bit i for column i) does not match. An error on an uncared byte does not prevent a match.
- R7: `found_n` falls in the cycle after a strobe that matches. It stays low until the next accepted table write. Headers without `hdr_valid` have no effect, and neither do non-matching headers. `found_n` low and `looking` high never occur together.
- R8: Every accepted table write sets `looking` to 1 and `found_n` to 1 in the following cycle. A matching header clears `looking`.
- R9: A matching header with the hold bit set raises `capture_en` in the next cycle and records its magazine. A later non-matching strobe with that magazine clears `capture_en`. Strobes from other magazines leave it high.
- R10: A matching header while the hold bit is 0 does not raise `capture_en`.
- R11: When an accepted write and a matching header fall in the same cycle, the write wins: `found_n` is 1 and `looking` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_we | input | 1 | Load the write pointer |
| cfg_start_col | input | 3 | Start column for the pointer |
| cfg_data_we | input | 1 | Write one request byte at the pointer |
| cfg_data | input | 5 | Request byte (bit 4 do-care) |
| hdr_valid | input | 1 | Header strobe |
| hdr_mag | input | 3 | Received magazine |
| hdr_pt | input | 4 | Received page tens |
| hdr_pu | input | 4 | Received page units |
| hdr_ht | input | 2 | Received hours tens |
| hdr_hu | input | 4 | Received hours units |
| hdr_mt | input | 3 | Received minutes tens |
| hdr_mu | input | 4 | Received minutes units |
| hdr_ham_err | input | 7 | Per-byte Hamming error flags, bit i for column i |
| found_n | output | 1 | Low once the requested page is found |
| looking | output | 1 | Request pending and not yet found |
| capture_en | output | 1 | Capture of the matched page is enabled |

## Verification
The bench loads the pointer at column 6 and at column 7 and then writes past them. A design that wrapped wrongly or stored into column 7 would leave the old magazine flag in column 0. The bench raises the pointer load and the data write in the same cycle and then sends a header that only matches if the dropped byte had been written. It writes the hours-tens entry with its upper bits set, which catches a compare that ignores digit width. It places Hamming errors on a cared byte and on an uncared byte. It sends strobes from a different magazine and from the same magazine to check when capture ends. Finally, it lands a table write on the same edge as a matching header to check that the write wins.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    localparam int NUM_COLS = 7;
    localparam int ENTRY_W  = 5;
    localparam int COL_W    = 3;
    localparam int DIG_W    = 4;
    localparam int CARE_BIT = 4;
    localparam int HOLD_BIT = 3;

    typedef struct packed {
        logic [2:0] mag;
        logic [3:0] pt;
        logic [3:0] pu;
        logic [1:0] ht;
        logic [3:0] hu;
        logic [2:0] mt;
        logic [3:0] mu;
    } hdr_t;

    // Significant width of the digit held in each column
    function automatic int digit_width(input int col);
        case (col)
            0:       return 3;
            3:       return 2;
            5:       return 3;
            default: return 4;
        endcase
    endfunction

    // Received digit for a column, zero-extended
    function automatic logic [DIG_W-1:0] digit_of(input hdr_t h, input int col);
        case (col)
            0:       return {1'b0, h.mag};
            1:       return h.pt;
            2:       return h.pu;
            3:       return {2'b00, h.ht};
            4:       return h.hu;
            5:       return {1'b0, h.mt};
            default: return h.mu;
        endcase
    endfunction

endpackage

// File: rtl/pgm_req_table.sv
module pgm_req_table
    import pgm_pkg::*;
#(
    parameter int COLS   = NUM_COLS,
    parameter int EW     = ENTRY_W,
    parameter int CW     = COL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_we,
    input  logic [CW-1:0]            start_col,
    input  logic                     data_we,
    input  logic [EW-1:0]            data_in,
    output logic [COLS-1:0][EW-1:0]  tab,
    output logic                     wr_accept
);

    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    logic [CW-1:0] wr_col;

    assign wr_accept = data_we && !start_we && (wr_col <= LAST_COL);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_col <= '0;
            tab    <= '0;
        end else if (start_we) begin
            wr_col <= start_col;
        end else if (data_we) begin
            if (wr_accept) begin
                tab[wr_col] <= data_in;
            end
            wr_col <= (wr_col >= LAST_COL) ? '0 : wr_col + 1'b1;
        end
    end

endmodule

// File: rtl/pgm_digit_cmp.sv
module pgm_digit_cmp
    import pgm_pkg::*;
#(
    parameter int COLS = NUM_COLS,
    parameter int EW   = ENTRY_W
) (
    input  logic [COLS-1:0][EW-1:0] tab,
    input  hdr_t                    hdr,
    input  logic [COLS-1:0]         ham_err,
    output logic                    match
);

    logic [COLS-1:0] col_ok;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int              W    = digit_width(c);
        localparam logic [DIG_W-1:0] MASK = DIG_W'((1 << W) - 1);
        logic [DIG_W-1:0] diff;
        assign diff      = (tab[c][DIG_W-1:0] ^ digit_of(hdr, c)) & MASK;
        assign col_ok[c] = !tab[c][CARE_BIT] || (!ham_err[c] && (diff == '0));
    end

    assign match = &col_ok;

endmodule

// File: rtl/pgm_capture_ctrl.sv
module pgm_capture_ctrl (
    input  logic       clk,
    input  logic       rst,
    input  logic       hdr_valid,
    input  logic [2:0] hdr_mag,
    input  logic       match,
    input  logic       hold,
    input  logic       wr_accept,
    output logic       found_n,
    output logic       looking,
    output logic       capture_en
);

    logic [2:0] cap_mag;
    logic       hit;

    assign hit = hdr_valid && match;

    always_ff @(posedge clk) begin
        if (rst) begin
            found_n <= 1'b1;
            looking <= 1'b0;
        end else if (wr_accept) begin
            found_n <= 1'b1;
            looking <= 1'b1;
        end else if (hit) begin
            found_n <= 1'b0;
            looking <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capture_en <= 1'b0;
            cap_mag    <= '0;
        end else if (hit && hold) begin
            capture_en <= 1'b1;
            cap_mag    <= hdr_mag;
        end else if (hdr_valid && capture_en && (hdr_mag == cap_mag)) begin
            capture_en <= 1'b0;
        end
    end

endmodule

// File: rtl/pgm_matcher.sv
module pgm_matcher
    import pgm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_start_we,
    input  logic [2:0] cfg_start_col,
    input  logic       cfg_data_we,
    input  logic [4:0] cfg_data,
    input  logic       hdr_valid,
    input  logic [2:0] hdr_mag,
    input  logic [3:0] hdr_pt,
    input  logic [3:0] hdr_pu,
    input  logic [1:0] hdr_ht,
    input  logic [3:0] hdr_hu,
    input  logic [2:0] hdr_mt,
    input  logic [3:0] hdr_mu,
    input  logic [6:0] hdr_ham_err,
    output logic       found_n,
    output logic       looking,
    output logic       capture_en
);

    logic [NUM_COLS-1:0][ENTRY_W-1:0] tab;
    logic                             wr_accept;
    logic                             match;
    hdr_t                             hdr;

    assign hdr = '{mag: hdr_mag, pt: hdr_pt, pu: hdr_pu, ht: hdr_ht,
                   hu: hdr_hu, mt: hdr_mt, mu: hdr_mu};

    pgm_req_table #(.COLS(NUM_COLS), .EW(ENTRY_W), .CW(COL_W)) u_tab (
        .clk       (clk),
        .rst       (rst),
        .start_we  (cfg_start_we),
        .start_col (cfg_start_col),
        .data_we   (cfg_data_we),
        .data_in   (cfg_data),
        .tab       (tab),
        .wr_accept (wr_accept)
    );

    pgm_digit_cmp #(.COLS(NUM_COLS), .EW(ENTRY_W)) u_cmp (
        .tab     (tab),
        .hdr     (hdr),
        .ham_err (hdr_ham_err),
        .match   (match)
    );

    pgm_capture_ctrl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .hdr_valid  (hdr_valid),
        .hdr_mag    (hdr_mag),
        .match      (match),
        .hold       (tab[0][HOLD_BIT]),
        .wr_accept  (wr_accept),
        .found_n    (found_n),
        .looking    (looking),
        .capture_en (capture_en)
    );

endmodule

// File: rtl/pgm_matcher_chk.sv
module pgm_matcher_chk (
    input logic clk,
    input logic rst,
    input logic hdr_valid,
    input logic wr_accept,
    input logic found_n,
    input logic looking,
    input logic capture_en
);

    a_r7_found_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(found_n) |-> $past(hdr_valid));

    a_r7_found_not_looking: assert property (@(posedge clk) disable iff (rst)
        !(!found_n && looking));

    a_r8_write_rearms: assert property (@(posedge clk) disable iff (rst)
        wr_accept |=> (looking && found_n));

    a_r9_capture_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(capture_en) |-> $past(hdr_valid));

    a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!hdr_valid && !wr_accept) |=>
            ($stable(found_n) && $stable(looking) && $stable(capture_en)));

endmodule

bind pgm_matcher pgm_matcher_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hdr_valid  (hdr_valid),
    .wr_accept  (wr_accept),
    .found_n    (found_n),
    .looking    (looking),
    .capture_en (capture_en)
);

// File: tb/pgm_matcher_test.sv
`timescale 1ns/1ps
module pgm_matcher_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_start_we = 1'b0;
    logic [2:0] cfg_start_col = '0;
    logic       cfg_data_we = 1'b0;
    logic [4:0] cfg_data = '0;
    logic       hdr_valid = 1'b0;
    logic [2:0] hdr_mag = '0;
    logic [3:0] hdr_pt = '0;
    logic [3:0] hdr_pu = '0;
    logic [1:0] hdr_ht = '0;
    logic [3:0] hdr_hu = '0;
    logic [2:0] hdr_mt = '0;
    logic [3:0] hdr_mu = '0;
    logic [6:0] hdr_ham_err = '0;
    logic       found_n, looking, capture_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pgm_matcher uut (
        .clk(clk), .rst(rst),
        .cfg_start_we(cfg_start_we), .cfg_start_col(cfg_start_col),
        .cfg_data_we(cfg_data_we), .cfg_data(cfg_data),
        .hdr_valid(hdr_valid), .hdr_mag(hdr_mag), .hdr_pt(hdr_pt),
        .hdr_pu(hdr_pu), .hdr_ht(hdr_ht), .hdr_hu(hdr_hu),
        .hdr_mt(hdr_mt), .hdr_mu(hdr_mu), .hdr_ham_err(hdr_ham_err),
        .found_n(found_n), .looking(looking), .capture_en(capture_en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_start(input logic [2:0] col);
        @(negedge clk);
        cfg_start_we = 1'b1; cfg_start_col = col;
        @(negedge clk);
        cfg_start_we = 1'b0;
    endtask

    task automatic write_byte(input logic [4:0] d);
        @(negedge clk);
        cfg_data_we = 1'b1; cfg_data = d;
        @(negedge clk);
        cfg_data_we = 1'b0;
    endtask

    task automatic drive_hdr(input logic v, input logic [2:0] m, input logic [3:0] pt,
                             input logic [3:0] pu, input logic [1:0] ht, input logic [3:0] hu,
                             input logic [2:0] mt, input logic [3:0] mu, input logic [6:0] e);
        hdr_valid = v; hdr_mag = m; hdr_pt = pt; hdr_pu = pu; hdr_ht = ht;
        hdr_hu = hu; hdr_mt = mt; hdr_mu = mu; hdr_ham_err = e;
    endtask

    task automatic send(input logic v, input logic [2:0] m, input logic [3:0] pt,
                        input logic [3:0] pu, input logic [1:0] ht, input logic [3:0] hu,
                        input logic [2:0] mt, input logic [3:0] mu, input logic [6:0] e);
        @(negedge clk);
        drive_hdr(v, m, pt, pu, ht, hu, mt, mu, e);
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 found_n reset", found_n, 1'b1);
        check("R1 looking reset", looking, 1'b0);
        check("R1 capture reset", capture_en, 1'b0);
        send(1'b1, 3'd5, 4'd9, 4'd9, 2'd1, 4'd1, 3'd1, 4'd1, 7'h00);
        check("R1 empty table matches", found_n, 1'b0);
        check("R10 hold zero no capture", capture_en, 1'b0);
    endtask

    task automatic t_program;
        set_start(3'd0);
        write_byte(5'h1B);
        write_byte(5'h11);
        write_byte(5'h15);
        check("R8 write sets looking", looking, 1'b1);
        check("R8 write raises found_n", found_n, 1'b1);
    endtask

    task automatic t_hamming;
        send(1'b1, 3'd3, 4'd1, 4'd5, 2'd0, 4'd0, 3'd0, 4'd0, 7'b0000010);
        check("R6 error on cared byte", found_n, 1'b1);
        send(1'b0, 3'd3, 4'd1, 4'd5, 2'd0, 4'd0, 3'd0, 4'd0, 7'h00);
        check("R7 no strobe ignored", found_n, 1'b1);
        send(1'b1, 3'd3, 4'd1, 4'd5, 2'd0, 4'd0, 3'd0, 4'd0, 7'b0001000);
        check("R6 error on uncared byte", found_n, 1'b0);
        check("R8 match clears looking", looking, 1'b0);
        check("R9 capture starts", capture_en, 1'b1);
    endtask

    task automatic t_capture;
        send(1'b1, 3'd2, 4'd9, 4'd5, 2'd0, 4'd0, 3'd0, 4'd0, 7'h00);
        check("R9 other magazine keeps capture", capture_en, 1'b1);
        send(1'b1, 3'd3, 4'd2, 4'd5, 2'd0, 4'd0, 3'd0, 4'd0, 7'h00);
        check("R9 same magazine ends capture", capture_en, 1'b0);
        check("R7 mismatch keeps found", found_n, 1'b0);
    endtask

    task automatic t_hold_low;
        set_start(3'd0);
        write_byte(5'h13);
        send(1'b1, 3'd3, 4'd1, 4'd5, 2'd0, 4'd0, 3'd0, 4'd0, 7'h00);
        check("R10 match found", found_n, 1'b0);
        check("R10 hold low no capture", capture_en, 1'b0);
    endtask

    task automatic t_start_priority;
        @(negedge clk);
        cfg_start_we = 1'b1; cfg_start_col = 3'd2;
        cfg_data_we = 1'b1;  cfg_data = 5'h00;
        @(negedge clk);
        cfg_start_we = 1'b0; cfg_data_we = 1'b0;
        write_byte(5'h15);
        send(1'b1, 3'd3, 4'd9, 4'd5, 2'd0, 4'd0, 3'd0, 4'd0, 7'h00);
        check("R4 dropped byte kept page tens", found_n, 1'b1);
    endtask

    task automatic t_timed;
        set_start(3'd3);
        write_byte(5'h1E);
        write_byte(5'h13);
        write_byte(5'h14);
        write_byte(5'h17);
        send(1'b1, 3'd3, 4'd1, 4'd5, 2'd2, 4'd3, 3'd4, 4'd7, 7'h00);
        check("R5 timed subpage match", found_n, 1'b0);
    endtask

    task automatic t_wrap;
        set_start(3'd6);
        write_byte(5'h17);
        write_byte(5'h0B);
        send(1'b1, 3'd5, 4'd1, 4'd5, 2'd2, 4'd3, 3'd4, 4'd7, 7'h00);
        check("R3 wrap wrote column 0", found_n, 1'b0);
        check("R9 hold set capture", capture_en, 1'b1);
        set_start(3'd6);
        write_byte(5'h17);
        send(1'b1, 3'd5, 4'd1, 4'd5, 2'd2, 4'd3, 3'd4, 4'd8, 7'h00);
        check("R5 minutes mismatch", found_n, 1'b1);
        check("R9 same magazine mismatch ends", capture_en, 1'b0);
    endtask

    task automatic t_col7;
        set_start(3'd7);
        write_byte(5'h00);
        write_byte(5'h1B);
        send(1'b1, 3'd5, 4'd1, 4'd5, 2'd2, 4'd3, 3'd4, 4'd7, 7'h00);
        check("R3 column 7 discarded then column 0", found_n, 1'b1);
        send(1'b1, 3'd3, 4'd1, 4'd5, 2'd2, 4'd3, 3'd4, 4'd7, 7'h00);
        check("R2 magazine field match", found_n, 1'b0);
        check("R2 hold bit position", capture_en, 1'b1);
    endtask

    task automatic t_concurrent;
        set_start(3'd6);
        @(negedge clk);
        cfg_data_we = 1'b1; cfg_data = 5'h17;
        drive_hdr(1'b1, 3'd3, 4'd1, 4'd5, 2'd2, 4'd3, 3'd4, 4'd7, 7'h00);
        @(negedge clk);
        cfg_data_we = 1'b0; hdr_valid = 1'b0;
        check("R11 write wins found_n", found_n, 1'b1);
        check("R11 write wins looking", looking, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_program;
        t_hamming;
        t_capture;
        t_hold_low;
        t_start_priority;
        t_timed;
        t_wrap;
        t_col7;
        t_concurrent;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule